// File: doc/BRIEF.md
# Self-Clocked Serial Result Transmitter

This block sends a 20-bit conversion result from a converter-side clock domain to a host over a serial link. The block produces the serial clock itself, so the host needs no clock of its own for the link. A free-running counter of input clock cycles splits every sampling interval into sixteen equal periods. Even-numbered periods are analog settling periods and odd-numbered periods are digital computation periods. A transfer can start only on the first cycle of a digital period, and only when the active-low select is low on that cycle.

Each new result arrives with a one-cycle valid strobe. The strobe restarts the interval counter and replaces the word in the output register. It also cancels any partial transfer and rewinds the bit position to the most significant bit. Bits leave MSB first, one bit for each group of four input clocks.

The host may raise select in the middle of a word. The bit in flight is completed, and the link then stops driving. A later low select picks up the word again at the next unsent bit, at the next polled boundary. Data-ready tells the host whether the current word is still waiting to be read. A word that is replaced before it was read shows up as a short high pulse on data-ready.

Top module: `sst_tx`

## Requirements
- R1: The interval counter restarts on a load strobe. A transfer starts only on the cycle after the first cycle of an odd-numbered 64-cycle period (period 1 starts 64 cycles after the load). A select that goes low later in a period waits for the next odd period.
- R2: A high `cs_n` on the polled cycle is ignored. Both output enables stay low for the whole interval, and `drdy` stays low while the word is unread.
- R3: A word is shifted out on `sdata` MSB first: 20 bits, each lasting 4 input clocks. While a transfer runs, `sclk_oe` and `sdata_oe` are both 1.
- R4: Within each bit, `sclk` is 0 for the first two clocks and 1 for the last two. `sdata` changes only when `sclk` falls and holds its value while `sclk` is high.
- R5: One cycle after the LSB's four clocks end, both output enables are 0 and `drdy` is 1. `drdy` stays at 1 until the next load.
- R6: If `cs_n` goes high during a bit, that bit still runs all four of its clocks. Both output enables go to 0 on the cycle that follows.
- R7: After a suspension, a low `cs_n` at the next polled cycle resumes at the next unsent bit. Bits are neither skipped nor repeated.
- R8: A load while the old word is unread (`drdy` 0) makes `drdy` 1 for exactly 4 input clocks after the load edge, then 0.
- R9: A load during a transfer drops both output enables on the next cycle. The next transfer starts again from the new word's MSB.
- R10: After synchronous reset, `drdy` is 1, `sclk` is 1 and both output enables are 0. No transfer starts until a word has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| result | input | 20 | New conversion result |
| result_vld | input | 1 | One-cycle strobe: load `result`, start a new interval |
| sclk | output | 1 | Generated serial clock, idles high |
| sdata | output | 1 | Serial data, MSB first |
| sclk_oe | output | 1 | Drive enable for `sclk` (0 = high impedance) |
| sdata_oe | output | 1 | Drive enable for `sdata` (0 = high impedance) |
| drdy | output | 1 | 0 while an unread word is waiting |

## Verification
The bench checks that a select which falls just after a polled cycle gets no clock until the next odd period. A design that watched select all the time would start too early. It suspends a word mid-bit and checks that the clock runs to the end of that bit. It then checks that the resumed stream starts at the next unsent bit, which catches an off-by-one index that repeats or drops a bit. It loads a word over an unread one and measures the data-ready pulse to the cycle, and it loads in the middle of a transfer to confirm that the new word starts from its MSB and not from the old bit position.

// File: rtl/sst_pkg.sv
// Package: shared types for the self-clocked serial transmitter.
// Assumes nothing beyond IEEE 1800-2017.
package sst_pkg;
    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_t;
endpackage

// File: rtl/sst_timebase.sv
// Module: sst_timebase
// Counts input clocks across one sampling interval of PERIODS periods of
// PERIOD_CYC cycles each. Odd periods are digital periods; poll is high on
// the first cycle of each digital period.
// Assumes PERIOD_CYC and PERIODS are powers of two.
module sst_timebase #(
    parameter int PERIOD_CYC = 64,
    parameter int PERIODS    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic poll
);
    localparam int TOTAL = PERIOD_CYC * PERIODS;
    localparam int CNT_W = $clog2(TOTAL);
    localparam int PER_W = $clog2(PERIOD_CYC);

    logic [CNT_W-1:0] cnt;

    // Interval counter: wraps at the end of the interval, restarts on a load.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (cnt == CNT_W'(TOTAL - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Poll strobe: first cycle of an odd (digital) period.
    always_comb begin
        poll = (cnt[PER_W-1:0] == '0) && cnt[PER_W];
    end
endmodule

// File: rtl/sst_shifter.sv
// Module: sst_shifter
// Holds the output word and shifts it out MSB first. Each bit lasts
// SCLK_DIV clocks: sclk is low in the first half and high in the second.
// A high cs_n suspends the transfer at the end of the current bit; the bit
// count survives so a later start resumes with the next bit.
// Assumes SCLK_DIV is even and at least 2.
module sst_shifter
    import sst_pkg::*;
#(
    parameter int WORD_W   = 20,
    parameter int SCLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              start,
    input  logic              cs_n,
    output logic              sclk,
    output logic              sdata,
    output logic              tx_active,
    output logic              last_done
);
    localparam int PH_W  = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
    localparam int IDX_W = $clog2(WORD_W + 1);
    localparam int HALF  = SCLK_DIV / 2;

    tx_state_t        state;
    logic [PH_W-1:0]  phase;
    logic [IDX_W-1:0] idx;
    logic [WORD_W-1:0] shreg;
    logic             bit_end;

    // Marks the final clock of the current bit.
    always_comb begin
        bit_end = (state == TX_SHIFT) && (phase == PH_W'(SCLK_DIV - 1));
    end

    // Transfer state, bit phase, bit count and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            phase <= '0;
            idx   <= '0;
            shreg <= '0;
        end else if (load) begin
            state <= TX_IDLE;
            phase <= '0;
            idx   <= '0;
            shreg <= word;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (start) begin
                        state <= TX_SHIFT;
                        phase <= '0;
                    end
                end
                TX_SHIFT: begin
                    if (bit_end) begin
                        phase <= '0;
                        idx   <= idx + 1'b1;
                        shreg <= {shreg[WORD_W-2:0], 1'b0};
                        if (idx == IDX_W'(WORD_W - 1) || cs_n) begin
                            state <= TX_IDLE;
                        end
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // Output decode: clock low in the first half of a bit, idle high.
    always_comb begin
        tx_active = (state == TX_SHIFT);
        sclk      = tx_active ? (phase >= PH_W'(HALF)) : 1'b1;
        sdata     = shreg[WORD_W-1];
        last_done = bit_end && (idx == IDX_W'(WORD_W - 1));
    end

    // R4: data may only move at a bit's first clock.
    p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && phase != '0) |-> $stable(sdata));

    // R6: the clock stops only after a whole bit, or when a load cancels it.
    p_whole_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_active) |-> ($past(phase) == PH_W'(SCLK_DIV - 1) || $past(load)));
endmodule

// File: rtl/sst_ready.sv
// Module: sst_ready
// Data-ready flag. It goes high after the last bit of a word. A load lowers
// it after a high window of RELOAD_CYC clocks, so an unread word that gets
// replaced shows as a fixed-length pulse.
// Assumes RELOAD_CYC is at least 1.
module sst_ready #(
    parameter int RELOAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic last_done,
    output logic drdy,
    output logic pending
);
    localparam int GAP_W = $clog2(RELOAD_CYC + 1);

    logic             sent;
    logic [GAP_W-1:0] gap;

    // Tracks whether the held word is fully sent and times the reload window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent <= 1'b1;
            gap  <= '0;
        end else if (load) begin
            sent <= 1'b0;
            gap  <= GAP_W'(RELOAD_CYC);
        end else begin
            if (gap != '0) begin
                gap <= gap - 1'b1;
            end
            if (last_done) begin
                sent <= 1'b1;
            end
        end
    end

    // Flag decode.
    always_comb begin
        drdy    = sent || (gap != '0);
        pending = !sent;
    end

    // R8: a load always raises the flag on the following cycle.
    p_load_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> drdy);
endmodule

// File: rtl/sst_tx.sv
// Module: sst_tx (top)
// Self-clocked serial result transmitter. It ties the interval timebase,
// the shifter and the data-ready logic together. A transfer starts on a
// polled digital-period boundary when select is low and a word is unread.
// Assumes result_vld is a single-cycle strobe.
module sst_tx #(
    parameter int WORD_W     = 20,
    parameter int PERIOD_CYC = 64,
    parameter int PERIODS    = 16,
    parameter int SCLK_DIV   = 4,
    parameter int RELOAD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [WORD_W-1:0] result,
    input  logic              result_vld,
    output logic              sclk,
    output logic              sdata,
    output logic              sclk_oe,
    output logic              sdata_oe,
    output logic              drdy
);
    logic poll;
    logic start;
    logic tx_active;
    logic last_done;
    logic pending;

    sst_timebase #(
        .PERIOD_CYC (PERIOD_CYC),
        .PERIODS    (PERIODS)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (result_vld),
        .poll    (poll)
    );

    // Start qualifier: polled boundary, select low, unread word present.
    always_comb begin
        start = poll && !cs_n && pending;
    end

    sst_shifter #(
        .WORD_W   (WORD_W),
        .SCLK_DIV (SCLK_DIV)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (result_vld),
        .word      (result),
        .start     (start),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdata     (sdata),
        .tx_active (tx_active),
        .last_done (last_done)
    );

    sst_ready #(
        .RELOAD_CYC (RELOAD_CYC)
    ) u_ready (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (result_vld),
        .last_done (last_done),
        .drdy      (drdy),
        .pending   (pending)
    );

    // Both lines share one drive condition.
    always_comb begin
        sclk_oe  = tx_active;
        sdata_oe = tx_active;
    end

    // R1: the link clock only wakes up right after a polled boundary with select low.
    p_start_polled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_oe) |-> ($past(poll) && !$past(cs_n)));

    // R5: ready and an active link never coincide.
    p_ready_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drdy |-> !sdata_oe);
endmodule

// File: tb/sim_sst_tx.sv
`timescale 1ns/1ps
module sim_sst_tx;
    localparam int W = 20;
    localparam int NVEC = 5;
    localparam logic [W-1:0] VEC [NVEC] = '{
        20'hA5C3F, 20'h00001, 20'h80000, 20'hFFFFF, 20'h5A0F6
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic [W-1:0] result = '0;
    logic         result_vld = 1'b0;
    logic         sclk, sdata, sclk_oe, sdata_oe, drdy;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sst_tx u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .result(result),
        .result_vld(result_vld), .sclk(sclk), .sdata(sdata),
        .sclk_oe(sclk_oe), .sdata_oe(sdata_oe), .drdy(drdy)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog act=%0d exp<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Load strobe; returns at the negedge right after the load edge.
    task automatic strobe(input logic [W-1:0] w);
        @(negedge clk);
        result = w;
        result_vld = 1'b1;
        @(negedge clk);
        result_vld = 1'b0;
    endtask

    // One bit: starts one negedge before phase 0, ends on phase 3.
    task automatic get_bit(output logic v);
        logic d0;
        @(negedge clk);
        chk("R4 sclk low ph0", sclk, 1'b0);
        chk("R3 oe during bit", {sclk_oe, sdata_oe}, 2'b11);
        d0 = sdata;
        @(negedge clk);
        @(negedge clk);
        chk("R4 sclk high ph2", sclk, 1'b1);
        chk("R4 sdata stable", sdata, d0);
        v = sdata;
        @(negedge clk);
    endtask

    task automatic get_bits(input int n, output logic [W-1:0] acc);
        logic b;
        acc = '0;
        for (int i = 0; i < n; i++) begin
            get_bit(b);
            acc = {acc[W-2:0], b};
        end
    endtask

    initial begin
        logic [W-1:0] got;
        int bad;
        // R10: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 drdy after reset", drdy, 1'b1);
        chk("R10 oe after reset", {sclk_oe, sdata_oe}, 2'b00);
        chk("R10 sclk idle", sclk, 1'b1);
        cs_n = 1'b0;
        bad = 0;
        repeat (200) begin
            @(negedge clk);
            if (sclk_oe) bad++;
        end
        chk("R10 no transfer without word", bad, 0);

        // R2: select high at every poll is ignored
        cs_n = 1'b1;
        strobe(20'h12345);
        bad = 0;
        repeat (1020) begin
            @(negedge clk);
            if (sclk_oe || sdata_oe) bad++;
        end
        chk("R2 oe stayed low", bad, 0);
        chk("R2 drdy low while unread", drdy, 1'b0);

        // R8: reload over an unread word
        strobe(20'h6789A);
        for (int k = 0; k < 4; k++) begin
            chk("R8 drdy high window", drdy, 1'b1);
            @(negedge clk);
        end
        chk("R8 drdy low after window", drdy, 1'b0);

        // Table walk: R1, R3, R5
        for (int v = 0; v < NVEC; v++) begin
            cs_n = 1'b0;
            strobe(VEC[v]);
            repeat (64) @(negedge clk);
            chk("R1 no start before poll", sclk_oe, 1'b0);
            get_bits(W, got);
            chk("R3 word MSB first", got, VEC[v]);
            @(negedge clk);
            chk("R5 drdy after LSB", drdy, 1'b1);
            chk("R5 oe off after LSB", {sclk_oe, sdata_oe}, 2'b00);
            repeat (60) @(negedge clk);
            chk("R5 drdy held", drdy, 1'b1);
        end

        // R6 / R7: suspend during bit 2, resume at next poll
        cs_n = 1'b0;
        strobe(20'hC3A96);
        repeat (64) @(negedge clk);
        get_bits(2, got);
        chk("R3 first two bits", got[1:0], 2'b11);
        @(negedge clk);
        cs_n = 1'b1;
        chk("R6 bit continues", {sclk_oe, sclk}, 2'b10);
        @(negedge clk);
        @(negedge clk);
        chk("R6 bit finishes high", {sclk_oe, sclk, sdata}, 3'b110);
        @(negedge clk);
        @(negedge clk);
        chk("R6 oe off after bit", {sclk_oe, sdata_oe}, 2'b00);
        cs_n = 1'b0;
        bad = 0;
        repeat (115) begin
            @(negedge clk);
            if (sclk_oe) bad++;
        end
        chk("R7 wait for next poll", bad, 0);
        chk("R7 drdy low while suspended", drdy, 1'b0);
        get_bits(17, got);
        chk("R7 resumed bits", got[16:0], 17'h03A96);
        @(negedge clk);
        chk("R5 drdy after resumed LSB", drdy, 1'b1);

        // R1 late select, then R9 load mid-transfer
        cs_n = 1'b1;
        strobe(20'h0F0F0);
        repeat (70) @(negedge clk);
        cs_n = 1'b0;
        repeat (122) @(negedge clk);
        chk("R1 late select waits", sclk_oe, 1'b0);
        @(negedge clk);
        chk("R1 start at next poll", sclk_oe, 1'b1);
        chk("R3 MSB value", sdata, 1'b0);
        @(negedge clk);
        strobe(20'hB1E27);
        chk("R9 load drops oe", {sclk_oe, sdata_oe}, 2'b00);
        repeat (64) @(negedge clk);
        get_bits(W, got);
        chk("R9 new word from MSB", got, 20'hB1E27);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule